// File: doc/BRIEF.md
# Bit-Serial SPI Master Shift Engine

This block is the serial core of an SPI master. Each start request moves one word of 1 to 32 bits across the link, most significant bit first. For every word the requester supplies the clock polarity, the clock phase, the bit count and a half-period length in system clock cycles. The engine drives the serial clock and the outgoing data line, samples the incoming data line, and hands back the received word with a one-cycle done pulse. Two per-word flags let the engine run as a transmit-only link or a receive-only link. Chip selects, queues and multi-word bursts belong to the logic around it.

The controller is a three-state machine. IDLE waits for a start. LEAD counts out the time before the leading clock edge of a bit. TRAIL counts out the time between the leading and trailing edges. The transitions are as follows. IDLE->LEAD happens on start, and the configuration is captured at that point. LEAD->TRAIL happens when the timer expires, together with the leading edge. TRAIL->LEAD happens when the timer expires and bits remain, together with the trailing edge. TRAIL->IDLE happens when the timer expires on the final bit, together with the trailing edge and the done pulse. A word is left-aligned in a shift register when it is loaded. Every sample shifts one received bit in at the bottom, so after N samples the received word sits right-aligned. The outgoing data register is written only when the next bit differs from the value last driven.

Top module: `spi_shift_master`

## Requirements
- R1: After reset sck_o, mosi_o, mosi_oe_o, busy_o, done_o and rx_word_o are all 0.
- R2: A start_i sampled in IDLE raises busy_o in the next cycle and captures cpol_i, cpha_i, no_tx_i, no_rx_i, nbits_i, dly_i and tx_word_i. A start_i sampled while busy_o is high is ignored, and the word in flight keeps its captured settings.
- R3: Outside a transfer sck_o rests at the captured CPOL level. Each bit makes exactly one leading edge (to the inverse of CPOL) and one trailing edge (back to CPOL), which is 2N edges per word.
- R4: Every interval between consecutive sck_o edges lasts max(dly,1) clock cycles. The interval from busy_o rising to the first leading edge also lasts max(dly,1) clock cycles, so a dly of 0 acts as 1.
- R5: With cpha_i=0, each bit is on mosi_o before its leading edge and holds through its trailing edge. miso_i is sampled on the leading edge.
- R6: With cpha_i=1, mosi_o takes the bit at its leading edge and holds until the trailing edge. miso_i is sampled on the trailing edge.
- R7: The word takes bits nbits_i-1 down to 0 of tx_word_i, most significant bit first. Bits above that are ignored. An nbits_i of 0 acts as 1, and a value above 32 acts as 32.
- R8: At the end of the word, rx_word_o holds the N received bits right-aligned, with zeros above them. done_o is high for exactly one cycle, and busy_o is already low in that cycle.
- R9: With no_tx_i set, mosi_oe_o stays 0 and mosi_o does not change for the whole word.
- R10: With no_rx_i set, miso_i is ignored and rx_word_o becomes 0.
- R11: mosi_o changes only where the next bit differs from the last driven value. The first bit of a word is always written, and mosi_oe_o rises with it and falls when the word ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one word transfer |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| no_tx_i | input | 1 | Do not drive the outgoing data line |
| no_rx_i | input | 1 | Ignore the incoming line and shift in zeros |
| nbits_i | input | 6 | Word length, 1 to 32 |
| dly_i | input | 16 | Half-period length in clock cycles |
| tx_word_i | input | 32 | Word to send, right-aligned |
| busy_o | output | 1 | A word is in flight |
| done_o | output | 1 | One-cycle pulse at the end of a word |
| rx_word_o | output | 32 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Outgoing serial data |
| mosi_oe_o | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Incoming serial data |

## Verification
The end of one word and the acceptance of the next can fall in the same cycle. The done pulse and the low busy_o of the finishing word coincide with the IDLE cycle in which a new start_i is sampled. The bench provokes this by raising start_i, with a new configuration, in the very cycle where it sees done_o. It then judges both words in full: the first word's received value must be intact, and the second word must have a correct edge count, edge spacing, sent bits and received word. A separate case raises start_i, with altered settings, in the middle of a word. That word must finish exactly as if no request had arrived.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } spi_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic no_tx;
        logic no_rx;
    } spi_mode_s;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             expire_o
);

    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_eff;

    // A zero length still gives a one-cycle half period
    assign dly_eff  = (dly_i == '0) ? DLY_W'(1) : dly_i;
    assign expire_o = (cnt_q == DLY_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= dly_eff;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int MAX_BITS = 32,
    parameter int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [NB_W-1:0]     load_nbits_i,
    input  logic [MAX_BITS-1:0] word_i,
    input  logic                shift_i,
    input  logic                bit_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                msb_o,
    output logic [MAX_BITS-1:0] result_o
);

    logic [MAX_BITS-1:0] sh_q;
    logic [MAX_BITS-1:0] sh_next;
    logic [MAX_BITS-1:0] mask;
    logic [NB_W-1:0]     align;

    assign align   = NB_W'(MAX_BITS) - load_nbits_i;
    assign sh_next = {sh_q[MAX_BITS-2:0], bit_i};
    assign msb_o   = sh_q[MAX_BITS-1];

    always_comb begin
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = (i < int'(nbits_i));
        end
    end

    // Shifted view lets the final sample and the result land on one edge
    assign result_o = (shift_i ? sh_next : sh_q) & mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i << align;
        end else if (shift_i) begin
            sh_q <= sh_next;
        end
    end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_eng_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int DLY_W    = 16,
    parameter int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cpol_i,
    input  logic                cpha_i,
    input  logic                no_tx_i,
    input  logic                no_rx_i,
    input  logic [NB_W-1:0]     nbits_i,
    input  logic [DLY_W-1:0]    dly_i,
    input  logic [MAX_BITS-1:0] tx_word_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] rx_word_o,
    output logic                sck_o,
    output logic                mosi_o,
    output logic                mosi_oe_o,
    input  logic                miso_i
);

    spi_state_e          state_q, state_d;
    spi_mode_s           mode_q;
    logic [NB_W-1:0]     nbits_q;
    logic [NB_W-1:0]     rem_q;
    logic [DLY_W-1:0]    dly_q;
    logic                mosi_last_q;

    logic [NB_W-1:0]     nbits_eff;
    logic                first_bit;
    logic                start_ok;
    logic                expire;
    logic                lead_fire;
    logic                trail_fire;
    logic                last_bit;
    logic                finish;
    logic                sample;
    logic                tmr_load;
    logic [DLY_W-1:0]    tmr_dly;
    logic                wr_pt;
    logic                msb;
    logic [MAX_BITS-1:0] result;

    // Length clamp: 0 acts as 1, anything beyond the register acts as full width
    always_comb begin
        if (nbits_i == '0) begin
            nbits_eff = NB_W'(1);
        end else if (nbits_i > NB_W'(MAX_BITS)) begin
            nbits_eff = NB_W'(MAX_BITS);
        end else begin
            nbits_eff = nbits_i;
        end
    end

    assign first_bit  = tx_word_i[nbits_eff - NB_W'(1)];
    assign start_ok   = start_i && (state_q == ST_IDLE);
    assign lead_fire  = (state_q == ST_LEAD) && expire;
    assign trail_fire = (state_q == ST_TRAIL) && expire;
    assign last_bit   = (rem_q == NB_W'(1));
    assign finish     = trail_fire && last_bit;
    assign sample     = mode_q.cpha ? trail_fire : lead_fire;
    assign tmr_load   = start_ok || lead_fire || (trail_fire && !last_bit);
    assign tmr_dly    = start_ok ? dly_i : dly_q;
    assign wr_pt      = !mode_q.no_tx &&
                        (mode_q.cpha ? lead_fire : (trail_fire && !last_bit));
    assign busy_o     = (state_q != ST_IDLE);

    spi_half_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .dly_i    (tmr_dly),
        .expire_o (expire)
    );

    spi_shifter #(
        .MAX_BITS (MAX_BITS),
        .NB_W     (NB_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (start_ok),
        .load_nbits_i (nbits_eff),
        .word_i       (tx_word_i),
        .shift_i      (sample),
        .bit_i        (mode_q.no_rx ? 1'b0 : miso_i),
        .nbits_i      (nbits_q),
        .msb_o        (msb),
        .result_o     (result)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LEAD;
            ST_LEAD:  if (expire)  state_d = ST_TRAIL;
            ST_TRAIL: if (expire)  state_d = last_bit ? ST_IDLE : ST_LEAD;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            nbits_q <= '0;
            dly_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                mode_q  <= '{cpol: cpol_i, cpha: cpha_i, no_tx: no_tx_i, no_rx: no_rx_i};
                nbits_q <= nbits_eff;
                dly_q   <= dly_i;
                rem_q   <= nbits_eff;
            end else if (trail_fire) begin
                rem_q   <= rem_q - NB_W'(1);
            end
        end
    end

    // Outputs: serial clock, data line, completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_o       <= 1'b0;
            mosi_o      <= 1'b0;
            mosi_oe_o   <= 1'b0;
            mosi_last_q <= 1'b0;
            done_o      <= 1'b0;
            rx_word_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_ok) begin
                sck_o       <= cpol_i;
                mosi_last_q <= ~first_bit;
                if (!cpha_i && !no_tx_i) begin
                    mosi_o      <= first_bit;
                    mosi_last_q <= first_bit;
                    mosi_oe_o   <= 1'b1;
                end
            end else begin
                if (lead_fire) sck_o <= ~mode_q.cpol;
                if (trail_fire) sck_o <= mode_q.cpol;
                if (wr_pt) begin
                    mosi_oe_o <= 1'b1;
                    if (msb != mosi_last_q) begin
                        mosi_o      <= msb;
                        mosi_last_q <= msb;
                    end
                end
                if (finish) begin
                    mosi_oe_o <= 1'b0;
                    done_o    <= 1'b1;
                    rx_word_o <= result;
                end
            end
        end
    end

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_TRAIL) |-> (sck_o == mode_q.cpol)); // R3
    AST_SCK_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |-> (sck_o != mode_q.cpol)); // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mode_q) && $stable(nbits_q) && $stable(dly_q))); // R2
    AST_CPHA0_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && !mode_q.cpha && $past(state_q == ST_LEAD)) |-> $stable(mosi_o)); // R5
    AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL && $past(state_q == ST_TRAIL)) |-> $stable(mosi_o)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_NOTX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q.no_tx) |-> (!mosi_oe_o && $stable(mosi_o))); // R9
    AST_NORX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q.no_rx) |-> (rx_word_o == '0)); // R10
    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mosi_oe_o); // R11

endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cpol_i = 1'b0;
    logic        cpha_i = 1'b0;
    logic        no_tx_i = 1'b0;
    logic        no_rx_i = 1'b0;
    logic [5:0]  nbits_i = 6'd8;
    logic [15:0] dly_i = 16'd1;
    logic [31:0] tx_word_i = '0;
    logic        busy_o, done_o, sck_o, mosi_o, mosi_oe_o;
    logic [31:0] rx_word_o;
    logic        miso_i = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit wd_hit  = 0;

    // Slave model state
    bit          s_act = 0;
    bit          s_cpol, s_cpha;
    logic [31:0] s_word, s_cap;
    int          s_idx, s_edges, s_bad_iv, s_last_t, s_t0, s_dly, s_mosi_tr;
    bit          s_oe_seen;

    spi_shift_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cpol_i    (cpol_i),
        .cpha_i    (cpha_i),
        .no_tx_i   (no_tx_i),
        .no_rx_i   (no_rx_i),
        .nbits_i   (nbits_i),
        .dly_i     (dly_i),
        .tx_word_i (tx_word_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rx_word_o (rx_word_o),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .mosi_oe_o (mosi_oe_o),
        .miso_i    (miso_i)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Serial slave: shifts its word out on miso and captures mosi
    always @(sck_o) begin
        if (s_act) begin
            if (sck_o != s_cpol) begin
                if ((cyc - ((s_edges == 0) ? s_t0 : s_last_t)) != s_dly) s_bad_iv++;
                if (!s_cpha) begin
                    s_cap = {s_cap[30:0], mosi_o};
                end else begin
                    miso_i = (s_idx >= 0) ? s_word[s_idx] : 1'b0;
                    s_idx--;
                end
                s_edges++;
                s_last_t = cyc;
            end else if (s_edges % 2 == 1) begin
                if ((cyc - s_last_t) != s_dly) s_bad_iv++;
                if (!s_cpha) begin
                    s_idx--;
                    miso_i = (s_idx >= 0) ? s_word[s_idx] : 1'b0;
                end else begin
                    s_cap = {s_cap[30:0], mosi_o};
                end
                s_edges++;
                s_last_t = cyc;
            end
        end
    end

    always @(mosi_o) if (s_act) s_mosi_tr++;
    always @(posedge mosi_oe_o) if (s_act) s_oe_seen = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input bit cpol, input bit cpha, input bit ntx, input bit nrx,
                            input int nb, input int dly, input logic [31:0] tx,
                            input logic [31:0] slv, input bit poke, input bit chain);
        int          n_eff, d_eff, k, exp_tr;
        logic [31:0] mask;
        logic        prev;
        n_eff = (nb == 0) ? 1 : ((nb > 32) ? 32 : nb);
        d_eff = (dly == 0) ? 1 : dly;
        mask  = (n_eff == 32) ? 32'hFFFF_FFFF : ((32'h1 << n_eff) - 32'h1);
        prev  = mosi_o;
        exp_tr = 0;
        for (int i = n_eff - 1; i >= 0; i--) begin
            if (tx[i] != prev) exp_tr++;
            prev = tx[i];
        end
        if (ntx) exp_tr = 0;
        s_cpol = cpol; s_cpha = cpha; s_word = slv; s_idx = n_eff - 1;
        s_cap = '0; s_edges = 0; s_bad_iv = 0; s_dly = d_eff; s_mosi_tr = 0;
        s_oe_seen = 0; s_last_t = 0;
        if (!cpha) miso_i = slv[n_eff-1];
        s_act = 1;
        cpol_i = cpol; cpha_i = cpha; no_tx_i = ntx; no_rx_i = nrx;
        nbits_i = 6'(nb); dly_i = 16'(dly); tx_word_i = tx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        s_t0 = cyc;
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        chk(done_o == 1'b0, "R8", "no done at start", done_o, 0);
        k = 0;
        while (!done_o && k < 20000) begin
            if (poke && k == 2) begin
                start_i = 1'b1; nbits_i = 6'd3; cpol_i = ~cpol; tx_word_i = ~tx; dly_i = 16'd7;
            end
            if (poke && k == 3) start_i = 1'b0;
            @(negedge clk);
            k++;
        end
        s_act = 0;
        chk(done_o == 1'b1, "R8", "done reached", done_o, 1);
        chk(busy_o == 1'b0, "R8", "busy low with done", busy_o, 0);
        chk(rx_word_o == (nrx ? 32'h0 : (slv & mask)), nrx ? "R10" : "R8", "rx word",
            rx_word_o, nrx ? 32'h0 : (slv & mask));
        chk(s_edges == 2 * n_eff, "R3", "sck edge count", s_edges, 2 * n_eff);
        chk(sck_o == cpol, "R3", "sck rests at cpol", sck_o, cpol);
        chk(s_bad_iv == 0, "R4", "half-period spacing errors", s_bad_iv, 0);
        if (ntx) begin
            chk(s_oe_seen == 0, "R9", "oe stayed low", s_oe_seen, 0);
        end else begin
            chk((s_cap & mask) == (tx & mask), cpha ? "R6" : "R5", "bits seen by slave (R7 order)",
                s_cap & mask, tx & mask);
            chk(s_oe_seen == 1, "R11", "oe raised", s_oe_seen, 1);
            chk(mosi_oe_o == 1'b0, "R11", "oe dropped at end", mosi_oe_o, 0);
        end
        chk(s_mosi_tr == exp_tr, ntx ? "R9" : "R11", "mosi transitions", s_mosi_tr, exp_tr);
        if (!chain) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R8", "done single cycle", done_o, 0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({sck_o, mosi_o, mosi_oe_o, busy_o, done_o} == 5'b0, "R1", "reset outputs",
            {sck_o, mosi_o, mosi_oe_o, busy_o, done_o}, 0);
        chk(rx_word_o == 32'h0, "R1", "reset rx word", rx_word_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_mode0;    run_xfer(0, 0, 0, 0, 8, 2, 32'hA5, 32'h3C, 0, 0);                endtask
    task automatic t_mode1;    run_xfer(0, 1, 0, 0, 16, 1, 32'h1234, 32'hBEEF, 0, 0);          endtask
    task automatic t_mode2;    run_xfer(1, 0, 0, 0, 32, 3, 32'hDEADBEEF, 32'h8001F00D, 0, 0);  endtask
    task automatic t_mode3_d0; run_xfer(1, 1, 0, 0, 1, 0, 32'h1, 32'h1, 0, 0);                 endtask
    task automatic t_len_zero; run_xfer(0, 0, 0, 0, 0, 1, 32'h0, 32'h1, 0, 0);                 endtask // R7
    task automatic t_len_big;  run_xfer(0, 1, 0, 0, 40, 1, 32'hC0FFEE11, 32'h76543210, 0, 0); endtask // R7
    task automatic t_junk_hi;  run_xfer(0, 0, 0, 0, 5, 2, 32'hFFFF_FF6A, 32'hFFFF_FFF5, 0, 0);endtask // R7
    task automatic t_no_tx;    run_xfer(0, 1, 1, 0, 12, 2, 32'hFFF, 32'h9A5, 0, 0);            endtask // R9
    task automatic t_no_rx;    run_xfer(1, 0, 0, 1, 10, 1, 32'h2B3, 32'h3FF, 0, 0);            endtask // R10
    task automatic t_busy_poke;run_xfer(0, 0, 0, 0, 8, 2, 32'h5A, 32'hC3, 1, 0);               endtask // R2
    task automatic t_chain;
        run_xfer(1, 1, 0, 0, 6, 1, 32'h2D, 32'h15, 0, 1);
        run_xfer(0, 0, 0, 0, 9, 2, 32'h1C7, 32'h0AA, 0, 0);
    endtask

    initial begin
        t_reset;
        t_mode0;
        t_mode1;
        t_mode2;
        t_mode3_d0;
        t_len_zero;
        t_len_big;
        t_junk_hi;
        t_no_tx;
        t_no_rx;
        t_busy_poke;
        t_chain;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule